// File: doc/BRIEF.md
# Two-Slot Spill/Refill Word Cache

This block keeps a short first-in, first-out window of parameter words between a real-time producer and a consumer. Two registers hold the oldest words, and the consumer always sees the oldest one. If a new word cannot be stored locally, it is spilled to a shared external synchronous memory through a write handshake with the memory arbiter. When the local window has room and the external memory reports that it holds words, the block fetches the oldest stored word back through a read handshake. Words therefore reach the consumer in the order they were accepted.

A state register tracks the cache. It has three resting states, which depend on how many words are held (none, one, two), and three transfer states: a read outstanding, a write outstanding, and both outstanding. The external memory is modelled by the arbiter side. The block sees only the request/acknowledge pairs and a memory-empty flag.

Top module: `spill_cache`

## Requirements
- R1: After reset, out_valid, mem_wr_req and mem_rd_req are all low.
- R2: out_valid is high exactly when at least one word is held locally. out_data then shows the oldest held word. Words reach the consumer in acceptance order. A word held locally or in memory is older than every word that arrives after it.
- R3: A new word (in_valid high) is stored locally, and is visible after the next clock edge, only if all of the following hold in that cycle: mem_empty is high, no transfer is outstanding, and either fewer than two words are held or the head is acknowledged.
- R4: A new word that cannot be stored locally is captured for a spill. mem_wr_req rises after the next edge with mem_wr_data equal to that word, and the locally held words are unchanged.
- R5: mem_wr_req and mem_wr_data stay unchanged until mem_wr_ok is sampled high. mem_wr_req then falls after that edge, unless a new spill is captured in the same cycle.
- R6: A read starts (mem_rd_req high after the edge) only if all of the following hold: mem_empty is low, no read is outstanding, and at most one word remains held after the cycle's operations. mem_rd_req stays high until mem_rd_ok. The returned mem_rd_data becomes the youngest local word.
- R7: While the external memory is non-empty or a transfer is outstanding, every new word is spilled even if a local slot is free.
- R8: A new word that arrives together with an acknowledge while the external memory is non-empty and nothing is outstanding causes both mem_wr_req and mem_rd_req to be high after the next edge.
- R9: A new word that arrives while a spill is outstanding and mem_wr_ok is low is discarded. It never appears at mem_wr_data or out_data.
- R10: out_ack while out_valid is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New-word strobe from the producer |
| in_data | input | DATA_W | New word |
| out_valid | output | 1 | At least one word held locally |
| out_data | output | DATA_W | Oldest held word |
| out_ack | input | 1 | Consumer takes the oldest word |
| mem_empty | input | 1 | External memory holds no words |
| mem_wr_req | output | 1 | Spill write request to the arbiter |
| mem_wr_data | output | DATA_W | Word being spilled |
| mem_wr_ok | input | 1 | Arbiter accepted the spill write |
| mem_rd_req | output | 1 | Refill read request to the arbiter |
| mem_rd_ok | input | 1 | Arbiter returns the read word this cycle |
| mem_rd_data | input | DATA_W | Word returned by the refill read |

## Verification
The case most likely to break this block is a spill and a refill starting in the same cycle. It happens when the consumer acknowledges the head while a new word arrives and the external memory already holds words. A directed sequence builds exactly that condition and then checks that both requests are high together. It next grants both handshakes in one cycle and checks the order in which the two words later reach the consumer. A random phase with random grant latencies repeats such collisions many times. Every cycle it compares all outputs with a queue-based model of the local window and of the external memory.

// File: rtl/spill_cache_pkg.sv
package spill_cache_pkg;

  typedef enum logic [2:0] {
    SC_EMPTY = 3'd0,
    SC_PART  = 3'd1,
    SC_FULL  = 3'd2,
    SC_READ  = 3'd3,
    SC_WRITE = 3'd4,
    SC_RDWR  = 3'd5
  } sc_state_e;

  localparam int unsigned SC_SLOTS = 2;

endpackage

// File: rtl/spill_cache_slots.sv
module spill_cache_slots #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  output logic [DATA_W-1:0] head_data,
  output logic [1:0]        count
);
  import spill_cache_pkg::*;

  logic [DATA_W-1:0] slot_q [SC_SLOTS];
  logic              head_q;
  logic [1:0]        count_q;
  logic              wr_idx;
  logic              head_nx;
  logic [1:0]        count_nx;

  // the free slot after the head; when both are taken and the head
  // leaves in the same cycle, the head slot itself is reused
  assign wr_idx   = head_q ^ count_q[0];
  assign head_nx  = pop ? ~head_q : head_q;
  assign count_nx = count_q + {1'b0, push} - {1'b0, pop};

  generate
    for (genvar g = 0; g < SC_SLOTS; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && (wr_idx == 1'(g))) begin
          slot_q[g] <= push_data;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= 1'b0;
      count_q <= 2'd0;
    end else begin
      head_q  <= head_nx;
      count_q <= count_nx;
    end
  end

  assign head_data = slot_q[head_q];
  assign count     = count_q;

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == 2'd2 && !pop) |-> !push);

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == 2'd0) |-> !pop);

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q != 2'd3);

endmodule

// File: rtl/spill_cache_ctrl.sv
module spill_cache_ctrl #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              out_ack,
  input  logic [1:0]        count,
  input  logic              mem_empty,
  input  logic              mem_wr_ok,
  input  logic              mem_rd_ok,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              pop,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              mem_wr_req,
  output logic              mem_rd_req,
  output logic [DATA_W-1:0] mem_wr_data
);
  import spill_cache_pkg::*;

  sc_state_e         state_q, state_nx;
  logic [DATA_W-1:0] spill_q;
  logic              rd_pend, wr_pend;
  logic              room, take, spill_go, rd_done;
  logic              rd_nx, wr_nx;
  logic [2:0]        cnt_nx;

  always_comb begin
    rd_pend = (state_q == SC_READ)  || (state_q == SC_RDWR);
    wr_pend = (state_q == SC_WRITE) || (state_q == SC_RDWR);
  end

  always_comb begin
    pop      = out_ack && (count != 2'd0);
    room     = (count != 2'd2) || pop;
    take     = in_valid && mem_empty && !wr_pend && !rd_pend && room;
    spill_go = in_valid && !take && (!wr_pend || mem_wr_ok);
    rd_done  = rd_pend && mem_rd_ok;
    push     = take || rd_done;
    push_data = rd_done ? mem_rd_data : in_data;
    cnt_nx   = {1'b0, count} + {2'b00, push} - {2'b00, pop};
  end

  always_comb begin
    wr_nx = (wr_pend && !mem_wr_ok) || spill_go;
    if (rd_pend) begin
      rd_nx = !mem_rd_ok;
    end else begin
      rd_nx = !mem_empty && (cnt_nx <= 3'd1);
    end
    unique case ({rd_nx, wr_nx})
      2'b11:   state_nx = SC_RDWR;
      2'b10:   state_nx = SC_READ;
      2'b01:   state_nx = SC_WRITE;
      default: begin
        if (cnt_nx == 3'd0) begin
          state_nx = SC_EMPTY;
        end else if (cnt_nx == 3'd1) begin
          state_nx = SC_PART;
        end else begin
          state_nx = SC_FULL;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_EMPTY;
    end else begin
      state_q <= state_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spill_q <= '0;
    end else if (spill_go) begin
      spill_q <= in_data;
    end
  end

  assign mem_wr_req  = wr_pend;
  assign mem_rd_req  = rd_pend;
  assign mem_wr_data = spill_q;

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ok) |=> mem_wr_req);

  // R5
  wr_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ok) |=> $stable(mem_wr_data));

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ok) |=> mem_rd_req);

  // R6
  rd_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (count != 2'd2));

  // R7
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || mem_wr_req || !mem_empty) |-> !(push && !mem_rd_ok));

endmodule

// File: rtl/spill_cache.sv
module spill_cache #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ack,
  input  logic              mem_empty,
  output logic              mem_wr_req,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_ok,
  output logic              mem_rd_req,
  input  logic              mem_rd_ok,
  input  logic [DATA_W-1:0] mem_rd_data
);

  logic              pop, push;
  logic [DATA_W-1:0] push_data;
  logic [1:0]        count;

  spill_cache_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .out_ack     (out_ack),
    .count       (count),
    .mem_empty   (mem_empty),
    .mem_wr_ok   (mem_wr_ok),
    .mem_rd_ok   (mem_rd_ok),
    .mem_rd_data (mem_rd_data),
    .pop         (pop),
    .push        (push),
    .push_data   (push_data),
    .mem_wr_req  (mem_wr_req),
    .mem_rd_req  (mem_rd_req),
    .mem_wr_data (mem_wr_data)
  );

  spill_cache_slots #(.DATA_W(DATA_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop       (pop),
    .push      (push),
    .push_data (push_data),
    .head_data (out_data),
    .count     (count)
  );

  assign out_valid = (count != 2'd0);

  // R2
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ack) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/test_spill_cache.sv
module test_spill_cache;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_ack = 1'b0;
  logic          mem_empty = 1'b1;
  logic          mem_wr_req;
  logic [DW-1:0] mem_wr_data;
  logic          mem_wr_ok = 1'b0;
  logic          mem_rd_req;
  logic          mem_rd_ok = 1'b0;
  logic [DW-1:0] mem_rd_data = '0;

  always #10 clk = ~clk;

  spill_cache #(.DATA_W(DW)) i_spill_cache (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_ack(out_ack),
    .mem_empty(mem_empty), .mem_wr_req(mem_wr_req), .mem_wr_data(mem_wr_data),
    .mem_wr_ok(mem_wr_ok), .mem_rd_req(mem_rd_req), .mem_rd_ok(mem_rd_ok),
    .mem_rd_data(mem_rd_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] cq[$];
  logic [DW-1:0] memq[$];
  bit            m_wp = 1'b0;
  bit            m_rp = 1'b0;
  logic [DW-1:0] m_wd = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(out_valid == (cq.size() > 0), "R2 out_valid", int'(out_valid), int'(cq.size() > 0));
    if (cq.size() > 0) chk(out_data == cq[0], "R2 out_data", int'(out_data), int'(cq[0]));
    chk(mem_wr_req == m_wp, "R5 mem_wr_req", int'(mem_wr_req), int'(m_wp));
    if (m_wp) chk(mem_wr_data == m_wd, "R4 mem_wr_data", int'(mem_wr_data), int'(m_wd));
    chk(mem_rd_req == m_rp, "R6 mem_rd_req", int'(mem_rd_req), int'(m_rp));
  endtask

  // called at a falling edge: drives one cycle of inputs, advances the model,
  // and compares at the next falling edge
  task automatic step(input bit iv, input logic [DW-1:0] id, input bit ack,
                      input bit gw, input bit gr);
    bit wok, rok, me, pop, take, spill;
    logic [DW-1:0] rdat;
    wok  = gw && m_wp;
    rok  = gr && m_rp;
    rdat = DW'($urandom);
    if (rok) rdat = memq.pop_front();
    if (wok) memq.push_back(m_wd);
    me = (memq.size() == 0);
    in_valid = iv; in_data = id; out_ack = ack;
    mem_wr_ok = wok; mem_rd_ok = rok; mem_rd_data = rdat; mem_empty = me;
    pop   = ack && (cq.size() > 0);
    take  = iv && me && !m_wp && !m_rp && ((cq.size() < 2) || pop);
    spill = iv && !take && (!m_wp || wok);
    if (pop)  void'(cq.pop_front());
    if (rok)  cq.push_back(rdat);
    if (take) cq.push_back(id);
    if (m_rp) m_rp = !rok;
    else      m_rp = !me && (cq.size() <= 1);
    m_wp = (m_wp && !wok) || spill;
    if (spill) m_wd = id;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
    chk(!mem_wr_req, "R1 mem_wr_req", int'(mem_wr_req), 0);
    chk(!mem_rd_req, "R1 mem_rd_req", int'(mem_rd_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !mem_wr_req && !mem_rd_req, "R1 idle", int'(out_valid), 0);

    step(1, 16'h0011, 0, 0, 0);
    chk(out_valid && out_data == 16'h0011, "R3 first word", int'(out_data), 16'h0011);
    step(1, 16'h0022, 0, 0, 0);
    step(1, 16'h0033, 0, 0, 0);
    // R4
    chk(mem_wr_req && mem_wr_data == 16'h0033, "R4 spill word", int'(mem_wr_data), 16'h0033);
    chk(out_data == 16'h0011, "R4 head kept", int'(out_data), 16'h0011);
    step(1, 16'h0044, 0, 0, 0);
    // R9
    chk(mem_wr_data == 16'h0033, "R9 dropped word", int'(mem_wr_data), 16'h0033);
    step(0, 16'h0000, 0, 1, 0);
    chk(!mem_wr_req, "R5 write released", int'(mem_wr_req), 0);
    step(1, 16'h0055, 1, 0, 0);
    // R8
    chk(mem_wr_req && mem_rd_req, "R8 both requests", int'({mem_wr_req, mem_rd_req}), 3);
    // R7
    chk(mem_wr_data == 16'h0055, "R7 spill with free slot", int'(mem_wr_data), 16'h0055);
    step(0, 16'h0000, 0, 1, 1);
    chk(!mem_rd_req && out_data == 16'h0022, "R6 refill done", int'(out_data), 16'h0022);
    step(0, 16'h0000, 1, 0, 0);
    chk(mem_rd_req && out_data == 16'h0033, "R6 refill restart", int'(out_data), 16'h0033);
    step(0, 16'h0000, 0, 0, 1);
    step(0, 16'h0000, 1, 0, 0);
    chk(out_data == 16'h0055, "R2 order after refill", int'(out_data), 16'h0055);
    step(0, 16'h0000, 1, 0, 0);
    chk(!out_valid, "R2 drained", int'(out_valid), 0);
    step(0, 16'h0000, 1, 0, 0);
    // R10
    chk(!out_valid && !mem_wr_req && !mem_rd_req, "R10 ack on empty", int'(out_valid), 0);

    step(1, 16'h00a1, 0, 0, 0);
    step(1, 16'h00a2, 0, 0, 0);
    step(1, 16'h00a3, 1, 0, 0);
    chk(!mem_wr_req && out_data == 16'h00a2, "R3 store with ack", int'(out_data), 16'h00a2);
    step(0, 16'h0000, 1, 0, 0);
    chk(out_data == 16'h00a3, "R3 next word", int'(out_data), 16'h00a3);
    step(0, 16'h0000, 1, 0, 0);

    for (int i = 0; i < 6000; i++) begin
      step(bit'($urandom_range(0, 1)), DW'(16'h1000 + i), bit'($urandom_range(0, 1)),
           ($urandom_range(0, 9) < 4), ($urandom_range(0, 9) < 4));
    end
    for (int i = 0; i < 60; i++) step(0, 16'h0000, 1, 1, 1);
    chk(!out_valid && memq.size() == 0, "R2 final drain", int'(memq.size()), 0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule